// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

This block moves 9-bit words between three ports, A, B and C. Any one port is the source, and its word can go to either of the other two ports or to both. Each port has its own input bus, output bus and valid flag, so no tristate pins are needed. A port whose output is off drives zeros and holds its valid flag low.

Each route passes through one of four holding stages. The stages are A toward C, C toward A, B toward C and C toward B, and each has its own enable. While its enable is low, a stage is transparent and the word goes through in the same cycle. While its enable is high, the stage holds the word it sampled at the last clock edge at which the enable was low. Because the word is held, a captured value can be sent back onto the port it came from, which helps with diagnostics.

A parity-invert control flips bit 8 on words that cross between C and A/B. This lets a test force a parity error. Bits 0 to 7 are never changed.

The route decoder has four named routes, selected by `sel`:

| `sel` | Route | Meaning |
|---|---|---|
| 00 | `SRC_A` | A is the source |
| 01 | `SRC_B` | B is the source |
| 10 | `SRC_C_VIA_A` | C is the source; a C readback uses the A-side path |
| 11 | `SRC_C_VIA_B` | C is the source; a C readback uses the B-side path |

The block is combinational apart from the four holding registers, so there are no other state transitions.

Top module: `pbx_exchanger`

## Requirements
- R1: A port whose output enable is low drives its output bus to 0 and holds its valid flag low. The valid flag is high whenever the enable is high, except for the case described in R8.
- R2: While a stage enable is low, the stage is transparent. A destination port shows the source word in the same cycle.
- R3: While a stage enable is high, the stage output equals the stage input sampled at the last rising clock edge at which that enable was low. The stage output stays stable while the enable remains high.
- R4: The routes work as follows:
  - `sel`=00: A is the source. B receives the word through the A→C stage, and C receives it through the same stage.
  - `sel`=01: B is the source. A receives the word through the B→C stage, and C receives it through the same stage.
  - `sel`=10 or 11: C is the source. A receives the word through the C→A stage, and B receives it through the C→B stage.
  - In every route, the port enables `oe_a`, `oe_b` and `oe_c` pick which destinations are driven.
- R5: When `par_inv`=1, bit 8 is inverted on every word that crosses between C and A/B. When `par_inv`=0, the word passes unchanged. Bits 0 to 7 are never altered, and a readback is never inverted.
- R6: Readback on A happens when `sel`=00 and `oe_a`=1. A then drives the A→C stage contents, and the B and C outputs still follow their own enables. This readback is only legal while `le_ac` is high.
- R7: Readback on B happens when `sel`=01 and `oe_b`=1. B then drives the B→C stage contents, and the other ports still follow their own enables. This readback is only legal while `le_bc` is high.
- R8: Readback on C happens when `oe_c`=1 and `sel` is 10 or 11. With `sel`=10, C drives the C→A stage contents and the A output is forced off. With `sel`=11, C drives the C→B stage contents and the B output is forced off. The stage used must be closed (its enable high).
- R9: Reset clears all four holding stages to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding stages |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 2 | Route select (00 A, 01 B, 10 C via A, 11 C via B) |
| oe_a | input | 1 | Output enable for port A |
| oe_b | input | 1 | Output enable for port B |
| oe_c | input | 1 | Output enable for port C |
| le_ac | input | 1 | Hold enable, A→C stage |
| le_ca | input | 1 | Hold enable, C→A stage |
| le_bc | input | 1 | Hold enable, B→C stage |
| le_cb | input | 1 | Hold enable, C→B stage |
| par_inv | input | 1 | Invert bit 8 on C↔A/B crossings |
| a_in | input | 9 | Port A input word |
| b_in | input | 9 | Port B input word |
| c_in | input | 9 | Port C input word |
| a_out | output | 9 | Port A output word |
| b_out | output | 9 | Port B output word |
| c_out | output | 9 | Port C output word |
| a_valid | output | 1 | Port A is driven |
| b_valid | output | 1 | Port B is driven |
| c_valid | output | 1 | Port C is driven |

## Verification
Some properties are checked by assertions on every cycle:
- disabled ports drive zero;
- a held stage keeps a stable output;
- a newly closed stage shows the word from the previous edge;
- the A-source route and the low bits on the B-to-C route pass through correctly;
- a C readback silences the port it borrows;
- no readback is attempted while its stage is open.

Other behaviour is shown only by the bench scenarios: the exact value that comes back on readback after a capture, the bit-8 inversion under `par_inv`, the zero contents after reset, and the full routing table over random control codes.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

    typedef enum logic [1:0] {
        SRC_A       = 2'd0,
        SRC_B       = 2'd1,
        SRC_C_VIA_A = 2'd2,
        SRC_C_VIA_B = 2'd3
    } route_e;

    // Stage index: 0 A->C, 1 C->A, 2 B->C, 3 C->B; NONE means port off
    typedef enum logic [2:0] {
        PICK_AC   = 3'd0,
        PICK_CA   = 3'd1,
        PICK_BC   = 3'd2,
        PICK_CB   = 3'd3,
        PICK_NONE = 3'd4
    } pick_e;

    typedef struct packed {
        pick_e pick;
        logic  inv;
    } drive_t;

    localparam int NUM_STAGES = 4;

endpackage

// File: rtl/pbx_latch.sv
module pbx_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;
    logic         armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held  <= '0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (!le) held <= d;
        end
    end

    assign q = le ? held : d;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && le && $past(le)) |-> $stable(q));

    // R3
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && le && !$past(le)) |-> (q == $past(d)));

endmodule

// File: rtl/pbx_route_dec.sv
module pbx_route_dec
    import pbx_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       oe_a,
    input  logic       oe_b,
    input  logic       oe_c,
    input  logic       par_inv,
    output drive_t     a_drv,
    output drive_t     b_drv,
    output drive_t     c_drv
);

    route_e route;
    assign route = route_e'(sel);

    always_comb begin
        a_drv = '{pick: PICK_NONE, inv: 1'b0};
        b_drv = '{pick: PICK_NONE, inv: 1'b0};
        c_drv = '{pick: PICK_NONE, inv: 1'b0};
        unique case (route)
            SRC_A: begin
                if (oe_a) a_drv = '{pick: PICK_AC, inv: 1'b0};
                if (oe_b) b_drv = '{pick: PICK_AC, inv: 1'b0};
                if (oe_c) c_drv = '{pick: PICK_AC, inv: par_inv};
            end
            SRC_B: begin
                if (oe_a) a_drv = '{pick: PICK_BC, inv: 1'b0};
                if (oe_b) b_drv = '{pick: PICK_BC, inv: 1'b0};
                if (oe_c) c_drv = '{pick: PICK_BC, inv: par_inv};
            end
            SRC_C_VIA_A: begin
                if (oe_a && !oe_c) a_drv = '{pick: PICK_CA, inv: par_inv};
                if (oe_b)          b_drv = '{pick: PICK_CB, inv: par_inv};
                if (oe_c)          c_drv = '{pick: PICK_CA, inv: 1'b0};
            end
            SRC_C_VIA_B: begin
                if (oe_a)          a_drv = '{pick: PICK_CA, inv: par_inv};
                if (oe_b && !oe_c) b_drv = '{pick: PICK_CB, inv: par_inv};
                if (oe_c)          c_drv = '{pick: PICK_CB, inv: 1'b0};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pbx_port_mux.sv
module pbx_port_mux
    import pbx_pkg::*;
#(
    parameter int W = 9
) (
    input  drive_t                       drv,
    input  logic [NUM_STAGES-1:0][W-1:0] q,
    output logic [W-1:0]                 out,
    output logic                         valid
);

    localparam logic [W-1:0] PAR_MASK = {1'b1, {(W-1){1'b0}}};

    always_comb begin
        if (drv.pick == PICK_NONE) begin
            out   = '0;
            valid = 1'b0;
        end else begin
            out   = q[drv.pick[1:0]] ^ (drv.inv ? PAR_MASK : '0);
            valid = 1'b1;
        end
    end

endmodule

// File: rtl/pbx_exchanger.sv
module pbx_exchanger
    import pbx_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   sel,
    input  logic         oe_a,
    input  logic         oe_b,
    input  logic         oe_c,
    input  logic         le_ac,
    input  logic         le_ca,
    input  logic         le_bc,
    input  logic         le_cb,
    input  logic         par_inv,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] c_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic [W-1:0] c_out,
    output logic         a_valid,
    output logic         b_valid,
    output logic         c_valid
);

    localparam logic [W-1:0] PAR_MASK = {1'b1, {(W-1){1'b0}}};

    logic [NUM_STAGES-1:0][W-1:0] stage_d;
    logic [NUM_STAGES-1:0][W-1:0] stage_q;
    logic [NUM_STAGES-1:0]        stage_le;
    drive_t                       drv [3];
    logic [2:0][W-1:0]            port_out;
    logic [2:0]                   port_valid;

    assign stage_d  = {c_in, b_in, c_in, a_in};
    assign stage_le = {le_cb, le_bc, le_ca, le_ac};

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        pbx_latch #(.W(W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .le    (stage_le[i]),
            .d     (stage_d[i]),
            .q     (stage_q[i])
        );
    end

    pbx_route_dec u_dec (
        .sel     (sel),
        .oe_a    (oe_a),
        .oe_b    (oe_b),
        .oe_c    (oe_c),
        .par_inv (par_inv),
        .a_drv   (drv[0]),
        .b_drv   (drv[1]),
        .c_drv   (drv[2])
    );

    for (genvar p = 0; p < 3; p++) begin : g_port
        pbx_port_mux #(.W(W)) u_mux (
            .drv   (drv[p]),
            .q     (stage_q),
            .out   (port_out[p]),
            .valid (port_valid[p])
        );
    end

    assign a_out   = port_out[0];
    assign b_out   = port_out[1];
    assign c_out   = port_out[2];
    assign a_valid = port_valid[0];
    assign b_valid = port_valid[1];
    assign c_valid = port_valid[2];

    // R1
    off_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_a |-> (!a_valid && a_out == '0)) and
        (!oe_b |-> (!b_valid && b_out == '0)) and
        (!oe_c |-> (!c_valid && c_out == '0)));

    // R6
    readback_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((sel == 2'b00 && oe_a && !le_ac) ||
          (sel == 2'b01 && oe_b && !le_bc) ||
          (sel == 2'b10 && oe_c && !le_ca) ||
          (sel == 2'b11 && oe_c && !le_cb)));

    // R5
    low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && c_valid && !le_bc) |-> (c_out[W-2:0] == b_in[W-2:0]));

    // R8
    c_readback_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[1] && oe_c) |-> !(sel[0] ? b_valid : a_valid));

    // R4
    a_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00 && oe_b && oe_c && !le_ac) |->
            (b_out == a_in && c_out == (a_in ^ (par_inv ? PAR_MASK : '0))));

endmodule

// File: tb/sim_pbx_exchanger.sv
`timescale 1ns/1ps
module sim_pbx_exchanger;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       oe_a = 1'b0, oe_b = 1'b0, oe_c = 1'b0;
    logic [3:0] le = 4'h0;      // 0 A->C, 1 C->A, 2 B->C, 3 C->B
    logic       par = 1'b0;
    logic [8:0] a_in = '0, b_in = '0, c_in = '0;
    logic [8:0] a_out, b_out, c_out;
    logic       a_valid, b_valid, c_valid;

    logic [8:0] mh [4];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pbx_exchanger #(.W(9)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c),
        .le_ac(le[0]), .le_ca(le[1]), .le_bc(le[2]), .le_cb(le[3]),
        .par_inv(par), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .a_out(a_out), .b_out(b_out), .c_out(c_out),
        .a_valid(a_valid), .b_valid(b_valid), .c_valid(c_valid)
    );

    function automatic logic [8:0] stage_in(int i);
        case (i)
            0:       return a_in;
            2:       return b_in;
            default: return c_in;
        endcase
    endfunction

    function automatic logic [8:0] lq(int i);
        return le[i] ? mh[i] : stage_in(i);
    endfunction

    function automatic logic [9:0] expect_port(int p);
        logic [8:0] m;
        m = par ? 9'h100 : 9'h000;
        case (sel)
            2'd0: case (p)
                0: return oe_a ? {1'b1, lq(0)} : 10'h0;
                1: return oe_b ? {1'b1, lq(0)} : 10'h0;
                default: return oe_c ? {1'b1, lq(0) ^ m} : 10'h0;
            endcase
            2'd1: case (p)
                0: return oe_a ? {1'b1, lq(2)} : 10'h0;
                1: return oe_b ? {1'b1, lq(2)} : 10'h0;
                default: return oe_c ? {1'b1, lq(2) ^ m} : 10'h0;
            endcase
            2'd2: case (p)
                0: return (oe_a && !oe_c) ? {1'b1, lq(1) ^ m} : 10'h0;
                1: return oe_b ? {1'b1, lq(3) ^ m} : 10'h0;
                default: return oe_c ? {1'b1, lq(1)} : 10'h0;
            endcase
            default: case (p)
                0: return oe_a ? {1'b1, lq(1) ^ m} : 10'h0;
                1: return (oe_b && !oe_c) ? {1'b1, lq(3) ^ m} : 10'h0;
                default: return oe_c ? {1'b1, lq(3)} : 10'h0;
            endcase
        endcase
    endfunction

    function automatic logic [9:0] actual_port(int p);
        case (p)
            0:       return {a_valid, a_out};
            1:       return {b_valid, b_out};
            default: return {c_valid, c_out};
        endcase
    endfunction

    task automatic check_val(string tag, string what, logic [9:0] act, logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_ports(string tag);
        for (int p = 0; p < 3; p++)
            check_val(tag, $sformatf("port%0d model", p), actual_port(p), expect_port(p));
    endtask

    // Advance one clock: model stages update from inputs held across the edge
    task automatic tick();
        @(posedge clk);
        for (int i = 0; i < 4; i++)
            if (!rst_n) mh[i] = '0;
            else if (!le[i]) mh[i] = stage_in(i);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 4; i++) mh[i] = '0;

        // R1: all ports off during reset
        a_in = 9'h1FF; b_in = 9'h0AB; c_in = 9'h133;
        tick(); tick();
        look(); check_ports("R1");
        check_val("R1", "a off", actual_port(0), 10'h0);
        tick();
        rst_n = 1'b1;

        // R9: stages zero after reset
        le = 4'hF; sel = 2'd0; oe_b = 1'b1; oe_c = 1'b1; a_in = 9'h1FF;
        look(); check_val("R9", "b held", actual_port(1), {1'b1, 9'h000});
        check_val("R9", "c held", actual_port(2), {1'b1, 9'h000});
        tick();

        // R2: transparent A to B and C
        le = 4'h0; a_in = 9'h1A5; par = 1'b0;
        look(); check_val("R2", "b", actual_port(1), {1'b1, 9'h1A5});
        check_val("R2", "c", actual_port(2), {1'b1, 9'h1A5});
        tick();

        // R5: parity invert only bit 8 toward C
        par = 1'b1;
        look(); check_val("R5", "c inv", actual_port(2), {1'b1, 9'h0A5});
        check_val("R5", "b plain", actual_port(1), {1'b1, 9'h1A5});
        tick();

        // R3: hold captured word while enable high
        le[0] = 1'b1; a_in = 9'h033;
        look(); check_val("R3", "b hold", actual_port(1), {1'b1, 9'h1A5});
        check_val("R3", "c hold", actual_port(2), {1'b1, 9'h0A5});
        tick();
        a_in = 9'h1C0;
        look(); check_val("R3", "b still", actual_port(1), {1'b1, 9'h1A5});
        tick();

        // R6: readback on A
        oe_a = 1'b1; oe_b = 1'b0; oe_c = 1'b0;
        look(); check_val("R6", "a rb", actual_port(0), {1'b1, 9'h1A5});
        check_val("R6", "b off", actual_port(1), 10'h0);
        check_val("R6", "c off", actual_port(2), 10'h0);
        tick();

        // R7: capture on B, then readback on B with A also driven
        sel = 2'd1; oe_a = 1'b0; le[2] = 1'b0; b_in = 9'h0F0;
        tick();
        le[2] = 1'b1; b_in = 9'h00F; oe_b = 1'b1; oe_a = 1'b1;
        look(); check_val("R7", "b rb", actual_port(1), {1'b1, 9'h0F0});
        check_val("R7", "a", actual_port(0), {1'b1, 9'h0F0});
        tick();

        // R8: readback on C via A path, A borrowed
        sel = 2'd2; oe_a = 1'b0; oe_b = 1'b0; le[1] = 1'b0; c_in = 9'h155;
        tick();
        le[1] = 1'b1; le[3] = 1'b0; c_in = 9'h0AA; par = 1'b0;
        oe_a = 1'b1; oe_b = 1'b1; oe_c = 1'b1;
        look(); check_val("R8", "c rb via A", actual_port(2), {1'b1, 9'h155});
        check_val("R8", "a borrowed", actual_port(0), 10'h0);
        check_val("R8", "b live", actual_port(1), {1'b1, 9'h0AA});
        tick();

        // R8/R5: readback on C via B path, B borrowed, no inversion on readback
        sel = 2'd3; le[3] = 1'b1; c_in = 9'h011; par = 1'b1;
        look(); check_val("R8", "c rb via B", actual_port(2), {1'b1, 9'h0AA});
        check_val("R8", "b borrowed", actual_port(1), 10'h0);
        check_val("R5", "a inv held", actual_port(0), {1'b1, 9'h055});
        tick();

        // R1: everything off
        oe_a = 1'b0; oe_b = 1'b0; oe_c = 1'b0;
        look(); check_ports("R1");
        check_val("R1", "c off", actual_port(2), 10'h0);
        tick();

        // R4: random routes against the model
        for (int k = 0; k < 600; k++) begin
            sel  = 2'($urandom_range(0, 3));
            oe_a = 1'($urandom_range(0, 1));
            oe_b = 1'($urandom_range(0, 1));
            oe_c = 1'($urandom_range(0, 1));
            le   = 4'($urandom_range(0, 15));
            par  = 1'($urandom_range(0, 1));
            a_in = 9'($urandom_range(0, 511));
            b_in = 9'($urandom_range(0, 511));
            c_in = 9'($urandom_range(0, 511));
            if (sel == 2'd0 && oe_a) le[0] = 1'b1;
            if (sel == 2'd1 && oe_b) le[2] = 1'b1;
            if (sel == 2'd2 && oe_c) le[1] = 1'b1;
            if (sel == 2'd3 && oe_c) le[3] = 1'b1;
            look(); check_ports("R4");
            tick();
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule